// File: doc/BRIEF.md
# Frame-Based SPI Transfer Engine

This block is the data path of an SPI master. Software fills a transmit queue with left-justified 32-bit words, programs a mode word that gives the word length and the number of words in a frame, and then raises a set of enables. The engine then shifts the whole frame out on `mosi` and assembles the bits sampled from `miso` into words in a receive queue. Software does nothing per word. Bit timing comes from an external clock block through a one-cycle `bitTick` strobe. Each strobe moves the frame by one bit.

Software writes through a small register port. The mode word sits at address 0, the control enables at address 1, status (write one to clear) at address 2 and the interrupt mask at address 3. Each control enable reads back on `ctrlState` only once the engine has taken it over. The intended bring-up order is clock, then receive, then transmit, then frame start. Teardown runs in the reverse order. At the end of a frame the engine raises separate transmit and receive end-of-frame flags. It drives `irq` when a flag is set and unmasked. Chip select is driven elsewhere.

Top module: `spi_frame_engine`

## Requirements
- R1: After reset, `ctrlState`, `statusWord` and `irq` are 0, `mosi` is 0, `rxEmpty` is 1 and `txFull` is 0.
- R2: The mode word carries word length minus one in bits [28:24] and word count minus one in bits [23:16]. A length below 8 is treated as 8 bits. A count above the queue depth (64) is cut to the depth.
- R3: In normal order, a B-bit word occupies bits [31:32-B] of its queue entry. Bit 31 goes out first, one bit per `bitTick`. The current bit is on `mosi` before the tick that consumes it. `mosi` is 0 outside a frame.
- R4: With mode bit 31 set (LSB first), bit 32-B of each queue entry goes out first and bit 31 goes out last.
- R5: Bits sampled from `miso` on each tick form a B-bit word. It is pushed into the receive queue left-justified in the same bit order as transmit, with bits below 32-B equal to 0.
- R6: With mode bit 0 set (no transmit data), the frame sends 0 bits and leaves the transmit queue untouched.
- R7: Control bits are clock enable (15), frame start (14), transmit enable (9) and receive enable (8). A written value appears on `ctrlState` after the second rising edge that follows the write edge, and not before.
- R8: A frame starts only on a rising edge of the applied frame-start bit while the clock enable is applied. Without the clock enable, ticks have no effect.
- R9: Status bit 23 (TX end of frame) and bit 7 (RX end of frame, receive enabled) are set on the edge that consumes the last bit of the last word. Writing a 1 to a status bit clears it.
- R10: `irq` is the OR of status bits whose bit in the interrupt mask (same positions, address 3) is 1.
- R11: A push into a full queue or a pop from an empty queue is ignored and sets sticky status bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | 0 mode, 1 control, 2 status clear, 3 interrupt mask |
| regWdata | input | 32 | Register write data |
| ctrlState | output | 16 | Applied control enables |
| statusWord | output | 32 | Status flags |
| irq | output | 1 | Interrupt request |
| txPush | input | 1 | Push `txData` into the transmit queue |
| txData | input | 32 | Transmit word, left-justified |
| txFull | output | 1 | Transmit queue full |
| rxPop | input | 1 | Remove the head of the receive queue |
| rxData | output | 32 | Head of the receive queue |
| rxEmpty | output | 1 | Receive queue empty |
| bitTick | input | 1 | One-cycle bit strobe from the clock block |
| miso | input | 1 | Serial data in |
| mosi | output | 1 | Serial data out |

## Verification
A wrong bit or word counter shows up at the ports within one frame. The end-of-frame flags then rise on the wrong tick, and `mosi` either repeats or skips bits at the next word boundary. A fault in the enable pipeline appears on `ctrlState` within two cycles of a control write. A queue pointer fault appears only when the affected word is popped or sent, which can be up to 64 words later. For that reason the bench runs a full-depth frame and drains the whole queue.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  localparam int WORD_W    = 32;
  localparam int CTRL_SCK  = 15;
  localparam int CTRL_FSE  = 14;
  localparam int CTRL_TXE  = 9;
  localparam int CTRL_RXE  = 8;
  localparam int ST_TXEOF  = 23;
  localparam int ST_RXEOF  = 7;
  localparam int ST_ERR    = 0;
  localparam int MODE_LSB  = 31;
  localparam int MODE_NOTX = 0;

  typedef struct packed {
    logic       active;
    logic       loadTx;
    logic       popTx;
    logic       shiftBit;
    logic       pushRx;
    logic       lsbFirst;
    logic [5:0] bitLen;
  } dpCtrl_t;
endpackage

// File: rtl/sfe_fifo.sv
module sfe_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [AW:0] count;
  logic doPush, doPop;

  assign full   = (count == (AW+1)'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign head   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == AW'(DEPTH-1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == AW'(DEPTH-1)) ? '0 : rdPtr + 1'b1;
      if (doPush && !doPop)      count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end

  // R11: occupancy never passes the depth
  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rstN)
    count <= (AW+1)'(DEPTH));
  // R11: a pop on an empty queue leaves it unchanged
  assert_empty_pop_ignored_R11: assert property (@(posedge clk) disable iff (!rstN)
    (pop && empty && !push) |=> $stable(count));
endmodule

// File: rtl/sfe_datapath.sv
module sfe_datapath
  import sfe_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           dp,
  input  logic              txPush,
  input  logic [WORD_W-1:0] txData,
  output logic              txFull,
  input  logic              rxPop,
  output logic [WORD_W-1:0] rxData,
  output logic              rxEmpty,
  input  logic              miso,
  output logic              mosi,
  output logic              errPulse
);
  logic [WORD_W-1:0] txHead, txSh, rxSh, rxNext, rxWord, txLoadVal;
  logic txEmpty, rxFull;
  logic [5:0] shiftAmt;

  function automatic logic [WORD_W-1:0] rev(input logic [WORD_W-1:0] v);
    for (int i = 0; i < WORD_W; i++) rev[i] = v[WORD_W-1-i];
  endfunction

  sfe_fifo #(.DEPTH(DEPTH), .W(WORD_W)) txQ (
    .clk(clk), .rstN(rstN), .push(txPush), .din(txData), .pop(dp.popTx),
    .head(txHead), .full(txFull), .empty(txEmpty));

  sfe_fifo #(.DEPTH(DEPTH), .W(WORD_W)) rxQ (
    .clk(clk), .rstN(rstN), .push(dp.pushRx), .din(rxWord), .pop(rxPop),
    .head(rxData), .full(rxFull), .empty(rxEmpty));

  assign shiftAmt = 6'(WORD_W) - dp.bitLen;
  assign rxNext   = {rxSh[WORD_W-2:0], miso};

  always_comb begin
    txLoadVal = '0;
    if (dp.popTx && !txEmpty)
      txLoadVal = dp.lsbFirst ? (rev(txHead) << shiftAmt) : txHead;
    rxWord = dp.lsbFirst ? (rev(rxNext) & ({WORD_W{1'b1}} << shiftAmt))
                         : (rxNext << shiftAmt);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txSh <= '0;
      rxSh <= '0;
    end else begin
      if (dp.loadTx)        txSh <= txLoadVal;
      else if (dp.shiftBit) txSh <= txSh << 1;
      if (dp.shiftBit)      rxSh <= rxNext;
    end
  end

  assign mosi     = dp.active && txSh[WORD_W-1];
  assign errPulse = (txPush && txFull) || (rxPop && rxEmpty) ||
                    (dp.popTx && txEmpty) || (dp.pushRx && rxFull);
endmodule

// File: rtl/sfe_control.sv
module sfe_control
  import sfe_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWdata,
  input  logic        bitTick,
  input  logic        errPulse,
  output dpCtrl_t     dp,
  output logic [15:0] ctrlState,
  output logic [31:0] statusWord,
  output logic        irq
);
  localparam int CNT_W = 8;
  localparam logic [CNT_W-1:0] LAST_MAX = CNT_W'(DEPTH-1);

  // enable vectors: [3] clock, [2] frame start, [1] transmit, [0] receive
  logic [3:0] req, stage, act;
  logic prevFse, frameOn;
  logic modeLsb, modeNoTx;
  logic [4:0] modeLen;
  logic [CNT_W-1:0] modeCnt;
  logic [5:0] bitCnt, lenReg, lenDec, lenOk;
  logic [CNT_W-1:0] wordCnt, lastReg, lastDec;
  logic lsbReg, noTxReg, txeFr, rxeFr;
  logic stTx, stRx, stErr, ieTx, ieRx, ieErr;
  logic startNow, shiftNow, wordEnd, lastWord, clrWe;
  logic unusedBits;

  assign unusedBits = ^regWdata;
  assign lenDec   = {1'b0, modeLen} + 6'd1;
  assign lenOk    = (lenDec < 6'd8) ? 6'd8 : lenDec;
  assign lastDec  = (modeCnt > LAST_MAX) ? LAST_MAX : modeCnt;
  assign startNow = !frameOn && act[2] && !prevFse && act[3];
  assign shiftNow = frameOn && act[3] && act[2] && bitTick;
  assign wordEnd  = shiftNow && (bitCnt == lenReg - 6'd1);
  assign lastWord = wordEnd && (wordCnt == lastReg);
  assign clrWe    = regWe && (regAddr == 2'd2);

  always_comb begin
    dp.active   = frameOn;
    dp.loadTx   = startNow || (wordEnd && !lastWord);
    dp.popTx    = startNow ? (act[1] && !modeNoTx)
                           : (wordEnd && !lastWord && txeFr && !noTxReg);
    dp.shiftBit = shiftNow;
    dp.pushRx   = wordEnd && rxeFr;
    dp.lsbFirst = startNow ? modeLsb : lsbReg;
    dp.bitLen   = startNow ? lenOk : lenReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      req <= '0; stage <= '0; act <= '0; prevFse <= 1'b0;
      modeLsb <= 1'b0; modeNoTx <= 1'b0; modeLen <= '0; modeCnt <= '0;
      ieTx <= 1'b0; ieRx <= 1'b0; ieErr <= 1'b0;
    end else begin
      stage   <= req;
      act     <= stage;
      prevFse <= act[2];
      if (regWe) begin
        case (regAddr)
          2'd0: begin
            modeLsb  <= regWdata[MODE_LSB];
            modeNoTx <= regWdata[MODE_NOTX];
            modeLen  <= regWdata[28:24];
            modeCnt  <= regWdata[23:16];
          end
          2'd1: req <= {regWdata[CTRL_SCK], regWdata[CTRL_FSE],
                        regWdata[CTRL_TXE], regWdata[CTRL_RXE]};
          2'd3: begin
            ieTx  <= regWdata[ST_TXEOF];
            ieRx  <= regWdata[ST_RXEOF];
            ieErr <= regWdata[ST_ERR];
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameOn <= 1'b0; bitCnt <= '0; wordCnt <= '0; lenReg <= 6'd8;
      lastReg <= '0; lsbReg <= 1'b0; noTxReg <= 1'b0;
      txeFr <= 1'b0; rxeFr <= 1'b0;
    end else if (startNow) begin
      frameOn <= 1'b1; bitCnt <= '0; wordCnt <= '0;
      lenReg  <= lenOk; lastReg <= lastDec; lsbReg <= modeLsb;
      noTxReg <= modeNoTx; txeFr <= act[1]; rxeFr <= act[0];
    end else if (frameOn && !act[2]) begin
      frameOn <= 1'b0;
    end else if (shiftNow) begin
      if (wordEnd) begin
        bitCnt <= '0;
        if (lastWord) frameOn <= 1'b0;
        else          wordCnt <= wordCnt + 1'b1;
      end else begin
        bitCnt <= bitCnt + 6'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stTx <= 1'b0; stRx <= 1'b0; stErr <= 1'b0;
    end else begin
      stTx  <= lastWord || (stTx && !(clrWe && regWdata[ST_TXEOF]));
      stRx  <= (lastWord && rxeFr) || (stRx && !(clrWe && regWdata[ST_RXEOF]));
      stErr <= errPulse || (stErr && !(clrWe && regWdata[ST_ERR]));
    end
  end

  always_comb begin
    ctrlState = '0;
    ctrlState[CTRL_SCK] = act[3];
    ctrlState[CTRL_FSE] = act[2];
    ctrlState[CTRL_TXE] = act[1];
    ctrlState[CTRL_RXE] = act[0];
    statusWord = '0;
    statusWord[ST_TXEOF] = stTx;
    statusWord[ST_RXEOF] = stRx;
    statusWord[ST_ERR]   = stErr;
  end

  assign irq = (stTx && ieTx) || (stRx && ieRx) || (stErr && ieErr);

  // R9: the TX end-of-frame flag rises only as a frame closes
  assert_eof_at_end_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stTx) |-> $fell(frameOn));
  // R2: bit counter stays inside the word length
  assert_bitcnt_R2: assert property (@(posedge clk) disable iff (!rstN)
    frameOn |-> (bitCnt < lenReg));
  // R2: word counter stays inside the clamped count
  assert_wordcnt_R2: assert property (@(posedge clk) disable iff (!rstN)
    frameOn |-> (wordCnt <= lastReg && lastReg <= LAST_MAX));
  // R8: a frame only begins with the clock enable applied
  assert_start_needs_clock_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameOn) |-> $past(act[3]));
  // R7: an applied enable was requested two edges earlier
  assert_enable_lag_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(act[3]) |-> $past(req[3], 2));
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import sfe_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [15:0] ctrlState,
  output logic [31:0] statusWord,
  output logic        irq,
  input  logic        txPush,
  input  logic [31:0] txData,
  output logic        txFull,
  input  logic        rxPop,
  output logic [31:0] rxData,
  output logic        rxEmpty,
  input  logic        bitTick,
  input  logic        miso,
  output logic        mosi
);
  dpCtrl_t dpStrobes;
  logic errPulse;

  sfe_control #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .bitTick(bitTick), .errPulse(errPulse),
    .dp(dpStrobes), .ctrlState(ctrlState), .statusWord(statusWord), .irq(irq));

  sfe_datapath #(.DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .dp(dpStrobes), .txPush(txPush), .txData(txData),
    .txFull(txFull), .rxPop(rxPop), .rxData(rxData), .rxEmpty(rxEmpty),
    .miso(miso), .mosi(mosi), .errPulse(errPulse));
endmodule

// File: tb/sim_spi_frame_engine.sv
`timescale 1ns/1ps
module sim_spi_frame_engine;
  logic clk = 1'b0, rstN = 1'b0;
  logic regWe = 1'b0;
  logic [1:0] regAddr = '0;
  logic [31:0] regWdata = '0, txData = '0;
  logic txPush = 1'b0, rxPop = 1'b0, bitTick = 1'b0, miso = 1'b0;
  wire [15:0] ctrlState;
  wire [31:0] statusWord, rxData;
  wire irq, txFull, rxEmpty, mosi;

  int nChecks = 0, nFail = 0, mosiBad = 0;
  logic [31:0] txBuf [0:63];
  logic [31:0] rxExp [0:63];
  bit doneFlag = 0;

  always #5 clk = ~clk;

  spi_frame_engine u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] actv, input logic [31:0] expv);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, actv, expv);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic pushTx(input logic [31:0] d);
    @(negedge clk); txPush = 1'b1; txData = d;
    @(negedge clk); txPush = 1'b0;
  endtask

  task automatic popRx(output logic [31:0] d);
    @(negedge clk); #1 d = rxData; rxPop = 1'b1;
    @(negedge clk); rxPop = 1'b0;
  endtask

  function automatic logic [31:0] mkMode(input bit lsb, input bit noTx, input int len, input int n);
    logic [4:0] l = 5'(len - 1);
    logic [7:0] c = 8'(n - 1);
    return {lsb, 2'b00, l, c, 15'b0, noTx};
  endfunction

  function automatic bit txBit(input logic [31:0] w, input int len, input bit lsb, input int i);
    return lsb ? w[32 - len + i] : w[31 - i];
  endfunction

  // shift a frame: compares mosi bit by bit, builds expected receive words
  task automatic doTicks(input int len, input int n, input bit lsb, input bit useTx);
    mosiBad = 0;
    for (int w = 0; w < n; w++) begin
      rxExp[w] = '0;
      for (int i = 0; i < len; i++) begin
        bit b = 1'($urandom % 2);
        bit e = useTx ? txBit(txBuf[w], len, lsb, i) : 1'b0;
        @(negedge clk); bitTick = 1'b1; miso = b;
        #1 if (mosi !== e) mosiBad++;
        if (lsb) rxExp[w][32 - len + i] = b; else rxExp[w][31 - i] = b;
        @(negedge clk); bitTick = 1'b0;
      end
    end
  endtask

  task automatic startFrame();
    regWrite(2'd1, 32'h0000_8300); idle(3);
    regWrite(2'd1, 32'h0000_C300); idle(3);
  endtask

  task automatic stopFrame();
    regWrite(2'd1, 32'h0000_8300); idle(3);
  endtask

  task automatic checkRx(input int n, input string tag);
    logic [31:0] d;
    for (int w = 0; w < n; w++) begin
      popRx(d);
      chk(d === rxExp[w], tag, d, rxExp[w]);
    end
  endtask

  initial begin
    int seedDummy;
    logic [31:0] d;
    seedDummy = $urandom(32'd4242);
    idle(3); rstN = 1'b1; idle(1);

    // R1 reset state
    chk(ctrlState === 16'h0, "R1 ctrl", {16'h0, ctrlState}, 32'h0);
    chk(statusWord === 32'h0, "R1 status", statusWord, 32'h0);
    chk(irq === 1'b0, "R1 irq", {31'h0, irq}, 32'h0);
    chk(rxEmpty === 1'b1 && txFull === 1'b0, "R1 queues", {30'h0, rxEmpty, txFull}, 32'h2);
    chk(mosi === 1'b0, "R3 idle mosi", {31'h0, mosi}, 32'h0);

    // R7 readback lag: written at edge E0, visible after E2
    @(negedge clk); regWe = 1'b1; regAddr = 2'd1; regWdata = 32'h0000_8000;
    @(negedge clk); regWe = 1'b0;
    chk(ctrlState === 16'h0, "R7 after E0", {16'h0, ctrlState}, 32'h0);
    @(negedge clk);
    chk(ctrlState === 16'h0, "R7 after E1", {16'h0, ctrlState}, 32'h0);
    @(negedge clk);
    chk(ctrlState === 16'h8000, "R7 after E2", {16'h0, ctrlState}, 32'h8000);
    regWrite(2'd1, 32'h0); idle(3);

    // R8 no clock enable: ticks do nothing
    regWrite(2'd0, mkMode(0, 0, 8, 1));
    regWrite(2'd1, 32'h0000_0300); idle(3);
    regWrite(2'd1, 32'h0000_4300); idle(3);
    chk(ctrlState === 16'h4300, "R7 readback", {16'h0, ctrlState}, 32'h4300);
    txBuf[0] = '0;
    doTicks(8, 1, 0, 1);
    chk(mosiBad == 0, "R8 mosi quiet", mosiBad, 0);
    chk(statusWord === 32'h0, "R8 no frame", statusWord, 32'h0);
    regWrite(2'd1, 32'h0); idle(3);

    // R2/R3/R4/R5/R9/R10 random frames
    regWrite(2'd3, 32'h0000_0080);
    for (int f = 0; f < 6; f++) begin
      int len = 8 + int'($urandom % 25);
      int n = 1 + int'($urandom % 4);
      bit lsb = 1'($urandom % 2);
      if (f == 0) lsb = 0;
      if (f == 1) begin lsb = 1; len = 12; end
      if (f == 2) len = 32;
      for (int w = 0; w < n; w++) begin txBuf[w] = $urandom; pushTx(txBuf[w]); end
      regWrite(2'd0, mkMode(lsb, 0, len, n));
      startFrame();
      doTicks(len, n, lsb, 1);
      idle(1);
      chk(mosiBad == 0, lsb ? "R4 mosi order" : "R3 mosi order", mosiBad, 0);
      chk(statusWord === 32'h0080_0080, "R9 eof flags", statusWord, 32'h0080_0080);
      if (f == 0) begin
        chk(irq === 1'b1, "R10 irq set", {31'h0, irq}, 32'h1);
        regWrite(2'd3, 32'h0);
        chk(irq === 1'b0, "R10 masked", {31'h0, irq}, 32'h0);
      end
      checkRx(n, "R5 rx word");
      regWrite(2'd2, 32'h0080_0080);
      chk(statusWord === 32'h0, "R9 w1c", statusWord, 32'h0);
      stopFrame();
    end

    // R6 no transmit data: zeros out, queue kept for the next frame
    txBuf[0] = $urandom; pushTx(txBuf[0]);
    regWrite(2'd0, mkMode(0, 1, 16, 2));
    startFrame();
    doTicks(16, 2, 0, 0);
    idle(1);
    chk(mosiBad == 0, "R6 idle data", mosiBad, 0);
    checkRx(2, "R5 rx in no-tx frame");
    regWrite(2'd2, 32'h0080_0080); stopFrame();
    regWrite(2'd0, mkMode(0, 0, 16, 1));
    startFrame();
    doTicks(16, 1, 0, 1);
    idle(1);
    chk(mosiBad == 0, "R6 queue untouched", mosiBad, 0);
    checkRx(1, "R5 rx");
    regWrite(2'd2, 32'h0080_0080); stopFrame();

    // R2 short length field treated as 8 bits
    txBuf[0] = $urandom; pushTx(txBuf[0]);
    regWrite(2'd0, 32'h0200_0000);
    startFrame();
    doTicks(8, 1, 0, 1);
    idle(1);
    chk(mosiBad == 0 && statusWord === 32'h0080_0080, "R2 length floor", statusWord, 32'h0080_0080);
    checkRx(1, "R2 8-bit rx");
    regWrite(2'd2, 32'h0080_0080); stopFrame();

    // R11 overflow, then R2 count clamp over a full queue
    for (int w = 0; w < 65; w++) begin
      d = $urandom;
      if (w < 64) txBuf[w] = d;
      pushTx(d);
    end
    idle(1);
    chk(txFull === 1'b1, "R11 full", {31'h0, txFull}, 32'h1);
    chk(statusWord === 32'h1, "R11 overflow sticky", statusWord, 32'h1);
    regWrite(2'd2, 32'h1);
    chk(statusWord === 32'h0, "R11 clear", statusWord, 32'h0);
    regWrite(2'd0, 32'h07FF_0000);
    startFrame();
    doTicks(8, 64, 0, 1);
    idle(1);
    chk(mosiBad == 0, "R2 clamp mosi", mosiBad, 0);
    chk(statusWord === 32'h0080_0080, "R2 clamp frame end", statusWord, 32'h0080_0080);
    checkRx(64, "R2 clamp rx");
    chk(rxEmpty === 1'b1, "R2 clamp drained", {31'h0, rxEmpty}, 32'h1);
    popRx(d); idle(1);
    chk(statusWord[0] === 1'b1 && rxEmpty === 1'b1, "R11 underflow", statusWord, 32'h0080_0081);
    stopFrame();

    doneFlag = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!doneFlag) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end
endmodule